// File: doc/BRIEF.md
# Dual-Port Burst RAM

This block is a synchronous memory that two independent requesters can use at the same time, through a left port and a right port. By default it holds 1024 words of 18 bits. Setting `ADDR_W` to 14 gives the full 16384-word array. Each word is split into two 9-bit byte lanes. Each port has its own address, write data, read data, chip selects, byte-lane selects, output enable and read/write line.

Each port keeps a burst address counter. A master can start a sequence by loading an address and then step through the following words without presenting a new address. The counter can also be cleared to zero. The counter's next value is the address used for that cycle's access.

Each port picks its own read latency. Flow-through returns data one clock after the access edge. Pipelined adds an output register, so data returns two clocks after the access edge. The tri-state data pads are split into separate write-data, read-data and per-lane drive-enable signals. Both ports run on one shared clock. If both ports write the same word on the same edge, the left port wins on every lane it writes, and both ports raise a collision flag.

Top module: `dual_burst_ram`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits. A written word reads back unchanged. A count step from address 2^ADDR_W-1 wraps to address 0.
- R2: When `*_strobe_n` is low and `*_zero_n` is high, the value on `*_addr` becomes the access address for that edge, and the counter holds it afterwards.
- R3: When `*_step_n` is low and both `*_strobe_n` and `*_zero_n` are high, the access address is the counter plus one. Step has no effect in a cycle where strobe or zero is low.
- R4: When `*_zero_n` is low, the access address for that edge is 0 and the counter becomes 0, whatever strobe and step are doing.
- R5: When zero, strobe and step are all high, the counter holds and the port accesses the same address again.
- R6: A port is selected only when `*_cs0_n` is low and `*_cs1` is high. A port that is not selected writes nothing and enables no read lane.
- R7: A selected port writes when `*_wr_n` is low and reads when it is high.
- R8: Lane 0 is bits 8:0 and is gated by `*_lo_n`. Lane 1 is bits 17:9 and is gated by `*_hi_n`. A write changes only the lanes whose select is low.
- R9: Read lane i is driven only when two conditions hold: its lane select was low at the access edge, and `*_oe_n` is low now. The bit of `*_rdata_oe` for a lane that is not driven is 0, and that lane's bits of `*_rdata` read 0.
- R10: With `*_pipe` low, read data appears in the cycle after the access edge. With `*_pipe` high, it appears one cycle later than that. `*_pipe` selects the output stage combinationally.
- R11: When both ports write the same address on one edge, the left port's data is stored on the lanes it writes. Lanes written only by the right port take the right port's data. `l_collide` and `r_collide` are both high for the following cycle.
- R12: A read of a word that the other port writes on the same edge returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| l_addr | input | ADDR_W | Left external address |
| l_strobe_n | input | 1 | Left counter load, active low |
| l_step_n | input | 1 | Left counter increment, active low |
| l_zero_n | input | 1 | Left counter clear, active low |
| l_cs0_n | input | 1 | Left chip select, active low |
| l_cs1 | input | 1 | Left chip select, active high |
| l_wr_n | input | 1 | Left write when low, read when high |
| l_lo_n | input | 1 | Left lane 0 select, active low |
| l_hi_n | input | 1 | Left lane 1 select, active low |
| l_oe_n | input | 1 | Left read output enable, active low |
| l_pipe | input | 1 | Left latency select, high for pipelined |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, 0 on lanes not driven |
| l_rdata_oe | output | 2 | Left per-lane drive enable |
| l_collide | output | 1 | Left same-word write collision flag |
| r_addr | input | ADDR_W | Right external address |
| r_strobe_n | input | 1 | Right counter load, active low |
| r_step_n | input | 1 | Right counter increment, active low |
| r_zero_n | input | 1 | Right counter clear, active low |
| r_cs0_n | input | 1 | Right chip select, active low |
| r_cs1 | input | 1 | Right chip select, active high |
| r_wr_n | input | 1 | Right write when low, read when high |
| r_lo_n | input | 1 | Right lane 0 select, active low |
| r_hi_n | input | 1 | Right lane 1 select, active low |
| r_oe_n | input | 1 | Right read output enable, active low |
| r_pipe | input | 1 | Right latency select, high for pipelined |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, 0 on lanes not driven |
| r_rdata_oe | output | 2 | Right per-lane drive enable |
| r_collide | output | 1 | Right same-word write collision flag |

## Verification
The bench fills a small array and runs a burst across the top address. A counter that fails to wrap reads an unwritten word, and one that is off by one returns the neighbour's data. It asserts strobe, step and zero together to test control priority. A design that lets step win returns the word after the loaded address, and one that lets strobe beat zero reads the strobed address instead of word 0. It sweeps latency, output enable and both lane selects through all sixteen combinations. A wrong stage choice shows stale data, and a wrong gate drives a lane that should float. Same-edge writes with partial lanes, and a read of a word the other port is writing, expose a core that lets the right port win, loses the right port's lane, or reads the new data.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int NPORTS = 2;
  localparam int LANES  = 2;

  // Counter action, in priority order from clear down to hold
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_STEP  = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } ctr_act_e;
endpackage

// File: rtl/dbr_addr_ctr.sv
module dbr_addr_ctr
  import dbr_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strobe_n,
  input  logic              step_n,
  input  logic              zero_n,
  output logic [ADDR_W-1:0] access_addr
);

  ctr_act_e          act;
  logic [ADDR_W-1:0] ctr_q;
  logic [ADDR_W-1:0] ctr_d;

  always_comb begin
    if (!zero_n)        act = ACT_CLEAR;
    else if (!strobe_n) act = ACT_LOAD;
    else if (!step_n)   act = ACT_STEP;
    else                act = ACT_HOLD;
  end

  always_comb begin
    case (act)
      ACT_CLEAR: ctr_d = '0;
      ACT_LOAD:  ctr_d = addr_in;
      ACT_STEP:  ctr_d = ctr_q + 1'b1;
      default:   ctr_d = ctr_q;
    endcase
  end

  assign access_addr = ctr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ctr_q <= '0;
    else if (act != ACT_HOLD) ctr_q <= ctr_d;
  end

  // R4
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_n |=> ctr_q == '0);

  // R2
  load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_n && !strobe_n) |=> ctr_q == $past(addr_in));

  // R3
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_n && strobe_n && !step_n) |=> ctr_q == ADDR_W'($past(ctr_q) + 1'b1));

  // R5
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_n && strobe_n && step_n) |=> $stable(ctr_q));

endmodule

// File: rtl/dbr_mem_core.sv
module dbr_mem_core
  import dbr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic [LANES-1:0]  l_lanes,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr,
  input  logic              r_rd,
  input  logic [LANES-1:0]  r_lanes,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] l_rword,
  output logic [DATA_W-1:0] r_rword,
  output logic              collide
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] l_bits, r_bits;
  logic [DATA_W-1:0] l_old, r_old;
  logic [DATA_W-1:0] l_word, r_word, both_word;
  logic              same_word;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign l_bits[i*LANE_W +: LANE_W] = {LANE_W{l_wr & l_lanes[i]}};
    assign r_bits[i*LANE_W +: LANE_W] = {LANE_W{r_wr & r_lanes[i]}};
  end

  assign l_old     = mem[l_addr];
  assign r_old     = mem[r_addr];
  assign same_word = l_wr && r_wr && (l_addr == r_addr);

  always_comb begin
    l_word    = (l_old & ~l_bits) | (l_wdata & l_bits);
    r_word    = (r_old & ~r_bits) | (r_wdata & r_bits);
    both_word = (l_old & ~(l_bits | r_bits))
              | (r_wdata & r_bits & ~l_bits)
              | (l_wdata & l_bits);
  end

  always_ff @(posedge clk) begin
    if (r_wr && !same_word) mem[r_addr] <= r_word;
    if (l_wr)               mem[l_addr] <= same_word ? both_word : l_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rword <= '0;
      r_rword <= '0;
      collide <= 1'b0;
    end else begin
      if (l_rd) l_rword <= l_old;
      if (r_rd) r_rword <= r_old;
      collide <= same_word;
    end
  end

  // R11
  collide_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    collide |-> ($past(l_wr) && $past(r_wr)));

endmodule

// File: rtl/dbr_read_out.sv
module dbr_read_out
  import dbr_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [LANES-1:0]  lane_req,
  input  logic [DATA_W-1:0] word_s1,
  input  logic              pipe,
  input  logic              oe_n,
  output logic [DATA_W-1:0] rdata,
  output logic [LANES-1:0]  rdata_oe
);

  localparam int LANE_W = DATA_W / LANES;

  logic [LANES-1:0]  lane_s1_q, lane_s1_d;
  logic [LANES-1:0]  lane_s2_q;
  logic [DATA_W-1:0] word_s2_q;
  logic [LANES-1:0]  lane_pick;
  logic [DATA_W-1:0] word_pick;

  assign lane_s1_d = rd_en ? lane_req : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_s1_q <= '0;
      lane_s2_q <= '0;
      word_s2_q <= '0;
    end else begin
      lane_s1_q <= lane_s1_d;
      lane_s2_q <= lane_s1_q;
      if (lane_s1_q != '0) word_s2_q <= word_s1;
    end
  end

  assign lane_pick = pipe ? lane_s2_q : lane_s1_q;
  assign word_pick = pipe ? word_s2_q : word_s1;
  assign rdata_oe  = lane_pick & {LANES{~oe_n}};

  for (genvar i = 0; i < LANES; i++) begin : g_gate
    assign rdata[i*LANE_W +: LANE_W] =
      rdata_oe[i] ? word_pick[i*LANE_W +: LANE_W] : '0;
  end

  // R10
  flow_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && rdata_oe[0]) |-> $past(rd_en && lane_req[0]));

  // R10
  pipe_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe && rdata_oe[1]) |-> $past(rd_en && lane_req[1], 2));

endmodule

// File: rtl/dual_burst_ram.sv
module dual_burst_ram
  import dbr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_strobe_n,
  input  logic              l_step_n,
  input  logic              l_zero_n,
  input  logic              l_cs0_n,
  input  logic              l_cs1,
  input  logic              l_wr_n,
  input  logic              l_lo_n,
  input  logic              l_hi_n,
  input  logic              l_oe_n,
  input  logic              l_pipe,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic [1:0]        l_rdata_oe,
  output logic              l_collide,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_strobe_n,
  input  logic              r_step_n,
  input  logic              r_zero_n,
  input  logic              r_cs0_n,
  input  logic              r_cs1,
  input  logic              r_wr_n,
  input  logic              r_lo_n,
  input  logic              r_hi_n,
  input  logic              r_oe_n,
  input  logic              r_pipe,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic [1:0]        r_rdata_oe,
  output logic              r_collide
);

  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  logic [ADDR_W-1:0] p_addr   [NPORTS];
  logic              p_strobe [NPORTS];
  logic              p_step   [NPORTS];
  logic              p_zero   [NPORTS];
  logic              p_cs0_n  [NPORTS];
  logic              p_cs1    [NPORTS];
  logic              p_wr_n   [NPORTS];
  logic [LANES-1:0]  p_lanes  [NPORTS];
  logic              p_oe_n   [NPORTS];
  logic              p_pipe   [NPORTS];
  logic              p_wr     [NPORTS];
  logic              p_rd     [NPORTS];
  logic [ADDR_W-1:0] p_acc    [NPORTS];
  logic [DATA_W-1:0] p_word   [NPORTS];
  logic [DATA_W-1:0] p_rdata  [NPORTS];
  logic [LANES-1:0]  p_rdoe   [NPORTS];
  logic              collide;

  assign p_addr[0]   = l_addr;     assign p_addr[1]   = r_addr;
  assign p_strobe[0] = l_strobe_n; assign p_strobe[1] = r_strobe_n;
  assign p_step[0]   = l_step_n;   assign p_step[1]   = r_step_n;
  assign p_zero[0]   = l_zero_n;   assign p_zero[1]   = r_zero_n;
  assign p_cs0_n[0]  = l_cs0_n;    assign p_cs0_n[1]  = r_cs0_n;
  assign p_cs1[0]    = l_cs1;      assign p_cs1[1]    = r_cs1;
  assign p_wr_n[0]   = l_wr_n;     assign p_wr_n[1]   = r_wr_n;
  assign p_lanes[0]  = {~l_hi_n, ~l_lo_n};
  assign p_lanes[1]  = {~r_hi_n, ~r_lo_n};
  assign p_oe_n[0]   = l_oe_n;     assign p_oe_n[1]   = r_oe_n;
  assign p_pipe[0]   = l_pipe;     assign p_pipe[1]   = r_pipe;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic sel;
    assign sel     = !p_cs0_n[p] && p_cs1[p];
    assign p_wr[p] = sel && !p_wr_n[p];
    assign p_rd[p] = sel &&  p_wr_n[p];

    dbr_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
      .clk         (clk),
      .rst_n       (core_rst_n),
      .addr_in     (p_addr[p]),
      .strobe_n    (p_strobe[p]),
      .step_n      (p_step[p]),
      .zero_n      (p_zero[p]),
      .access_addr (p_acc[p])
    );

    dbr_read_out #(.DATA_W(DATA_W)) u_out (
      .clk      (clk),
      .rst_n    (core_rst_n),
      .rd_en    (p_rd[p]),
      .lane_req (p_lanes[p]),
      .word_s1  (p_word[p]),
      .pipe     (p_pipe[p]),
      .oe_n     (p_oe_n[p]),
      .rdata    (p_rdata[p]),
      .rdata_oe (p_rdoe[p])
    );
  end

  dbr_mem_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .l_addr  (p_acc[0]),
    .l_wr    (p_wr[0]),
    .l_rd    (p_rd[0]),
    .l_lanes (p_lanes[0]),
    .l_wdata (l_wdata),
    .r_addr  (p_acc[1]),
    .r_wr    (p_wr[1]),
    .r_rd    (p_rd[1]),
    .r_lanes (p_lanes[1]),
    .r_wdata (r_wdata),
    .l_rword (p_word[0]),
    .r_rword (p_word[1]),
    .collide (collide)
  );

  assign l_rdata    = p_rdata[0];
  assign r_rdata    = p_rdata[1];
  assign l_rdata_oe = p_rdoe[0];
  assign r_rdata_oe = p_rdoe[1];
  assign l_collide  = collide;
  assign r_collide  = collide;

endmodule

// File: tb/dual_burst_ram_tb.sv
`timescale 1ns/1ps
module dual_burst_ram_tb;
  localparam int AW    = 6;
  localparam int DW    = 18;
  localparam int DEPTH = 1 << AW;
  localparam int LW    = DW / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0] addr [2];
  logic strobe_n [2], step_n [2], zero_n [2], cs0_n [2], cs1 [2];
  logic wr_n [2], lo_n [2], hi_n [2], oe_n [2], pipe [2];
  logic [DW-1:0] wdata [2];
  logic [DW-1:0] rdata [2];
  logic [1:0]    rdoe  [2];
  logic          coll  [2];

  dual_burst_ram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .l_addr(addr[0]), .l_strobe_n(strobe_n[0]), .l_step_n(step_n[0]), .l_zero_n(zero_n[0]),
    .l_cs0_n(cs0_n[0]), .l_cs1(cs1[0]), .l_wr_n(wr_n[0]), .l_lo_n(lo_n[0]), .l_hi_n(hi_n[0]),
    .l_oe_n(oe_n[0]), .l_pipe(pipe[0]), .l_wdata(wdata[0]),
    .l_rdata(rdata[0]), .l_rdata_oe(rdoe[0]), .l_collide(coll[0]),
    .r_addr(addr[1]), .r_strobe_n(strobe_n[1]), .r_step_n(step_n[1]), .r_zero_n(zero_n[1]),
    .r_cs0_n(cs0_n[1]), .r_cs1(cs1[1]), .r_wr_n(wr_n[1]), .r_lo_n(lo_n[1]), .r_hi_n(hi_n[1]),
    .r_oe_n(oe_n[1]), .r_pipe(pipe[1]), .r_wdata(wdata[1]),
    .r_rdata(rdata[1]), .r_rdata_oe(rdoe[1]), .r_collide(coll[1])
  );

  // Bench-side expectation state
  logic [DW-1:0] m_mem  [DEPTH];
  logic [AW-1:0] m_ctr  [2];
  logic [1:0]    m_l1   [2];
  logic [1:0]    m_l2   [2];
  logic [DW-1:0] m_w1   [2];
  logic [DW-1:0] m_w2   [2];
  logic          m_coll;

  int    checks = 0;
  int    fails  = 0;
  string phase  = "reset";

  function automatic logic [DW-1:0] lane_bits(logic [1:0] l);
    return {{LW{l[1]}}, {LW{l[0]}}};
  endfunction

  function automatic logic [DW-1:0] pat(int a, int salt);
    return DW'(a * 2731 + salt * 977 + 341);
  endfunction

  task automatic check_outputs();
    for (int p = 0; p < 2; p++) begin
      logic [1:0]    el;
      logic [DW-1:0] ew;
      el = (pipe[p] ? m_l2[p] : m_l1[p]) & {2{~oe_n[p]}};
      ew = (pipe[p] ? m_w2[p] : m_w1[p]) & lane_bits(el);
      checks++;
      if (rdoe[p] !== el) begin
        fails++;
        $display("FAIL %s port%0d lane enable actual %b expected %b", phase, p, rdoe[p], el);
      end
      checks++;
      if (rdata[p] !== ew) begin
        fails++;
        $display("FAIL %s port%0d rdata actual %h expected %h", phase, p, rdata[p], ew);
      end
      checks++;
      if (coll[p] !== m_coll) begin
        fails++;
        $display("FAIL %s port%0d collide actual %b expected %b", phase, p, coll[p], m_coll);
      end
    end
  endtask

  // One clock: predict from the driven inputs, advance, then compare
  task automatic tick();
    logic [AW-1:0] eff [2];
    logic          wr  [2], rd [2];
    logic [DW-1:0] old [2];
    logic          same;
    for (int p = 0; p < 2; p++) begin
      if (!zero_n[p])        eff[p] = '0;
      else if (!strobe_n[p]) eff[p] = addr[p];
      else if (!step_n[p])   eff[p] = m_ctr[p] + 1'b1;
      else                   eff[p] = m_ctr[p];
      wr[p]  = !cs0_n[p] && cs1[p] && !wr_n[p];
      rd[p]  = !cs0_n[p] && cs1[p] &&  wr_n[p];
      old[p] = m_mem[eff[p]];
    end
    same = wr[0] && wr[1] && (eff[0] == eff[1]);
    @(posedge clk);
    for (int q = 1; q >= 0; q--) begin
      if (wr[q]) begin
        logic [DW-1:0] b;
        b = lane_bits({~hi_n[q], ~lo_n[q]});
        m_mem[eff[q]] = (m_mem[eff[q]] & ~b) | (wdata[q] & b);
      end
    end
    for (int p = 0; p < 2; p++) begin
      m_l2[p]  = m_l1[p];
      m_w2[p]  = m_w1[p];
      m_l1[p]  = rd[p] ? {~hi_n[p], ~lo_n[p]} : 2'b00;
      if (rd[p]) m_w1[p] = old[p];
      m_ctr[p] = eff[p];
    end
    m_coll = same;
    @(negedge clk);
    check_outputs();
  endtask

  task automatic idle(int p);
    addr[p] = '0; strobe_n[p] = 1'b1; step_n[p] = 1'b1; zero_n[p] = 1'b1;
    cs0_n[p] = 1'b1; cs1[p] = 1'b0; wr_n[p] = 1'b1;
    lo_n[p] = 1'b1; hi_n[p] = 1'b1; wdata[p] = '0;
  endtask

  task automatic drive(int p, logic st, logic en, logic cl, logic [AW-1:0] a,
                       logic w, logic lo, logic hi, logic [DW-1:0] d);
    cs0_n[p] = 1'b0; cs1[p] = 1'b1;
    strobe_n[p] = st; step_n[p] = en; zero_n[p] = cl; addr[p] = a;
    wr_n[p] = w; lo_n[p] = lo; hi_n[p] = hi; wdata[p] = d;
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog expired during %s", phase);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      idle(p);
      oe_n[p] = 1'b1; pipe[p] = 1'b0;
      m_ctr[p] = '0; m_l1[p] = '0; m_l2[p] = '0; m_w1[p] = '0; m_w2[p] = '0;
    end
    m_coll = 1'b0;
    for (int a = 0; a < DEPTH; a++) m_mem[a] = 'x;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_outputs();
    rst_n = 1'b1;
    repeat (3) tick();

    // Fill by burst from the left port
    phase = "R1 R2 R3 R7 R8 burst fill";
    drive(0, 0, 1, 1, 0, 0, 0, 0, pat(0, 0)); tick();
    for (int i = 1; i < DEPTH; i++) begin
      drive(0, 1, 0, 1, 0, 0, 0, 0, pat(i, 0)); tick();
    end
    idle(0); tick();

    // Flow-through burst read with wrap
    phase = "R1 R10 flow read and wrap";
    oe_n[1] = 1'b0; pipe[1] = 1'b0;
    drive(1, 0, 1, 1, 0, 1, 0, 0, 0); tick();
    for (int i = 1; i <= DEPTH + 1; i++) begin
      drive(1, 1, 0, 1, 0, 1, 0, 0, 0); tick();
    end
    idle(1); tick(); tick();

    // Pipelined burst read on the left
    phase = "R10 pipelined read";
    oe_n[0] = 1'b0; pipe[0] = 1'b1;
    drive(0, 0, 1, 1, 5, 1, 0, 0, 0); tick();
    for (int i = 0; i < 10; i++) begin
      drive(0, 1, 0, 1, 0, 1, 0, 0, 0); tick();
    end
    idle(0); tick(); tick();

    phase = "R5 counter hold";
    drive(1, 0, 1, 1, 12, 1, 0, 0, 0); tick();
    drive(1, 1, 1, 1, 40, 1, 0, 0, 0); tick(); tick(); tick();

    phase = "R4 clear overrides strobe and step";
    drive(1, 0, 0, 0, 30, 1, 0, 0, 0); tick();
    drive(1, 1, 0, 1, 30, 1, 0, 0, 0); tick();

    phase = "R3 step ignored under strobe";
    drive(1, 0, 0, 1, 20, 1, 0, 0, 0); tick();
    drive(1, 1, 1, 1, 0, 1, 0, 0, 0); tick();

    phase = "R8 lane-masked writes";
    drive(0, 0, 1, 1, 3, 0, 0, 1, pat(3, 1)); tick();
    drive(0, 0, 1, 1, 4, 0, 1, 0, pat(4, 1)); tick();
    idle(0);
    drive(1, 0, 1, 1, 3, 1, 0, 0, 0); tick();
    drive(1, 1, 0, 1, 0, 1, 0, 0, 0); tick();
    idle(1); tick();

    phase = "R9 R10 latency, enable and lane sweep";
    for (int m = 0; m < 16; m++) begin
      pipe[1] = m[3]; oe_n[1] = m[2];
      drive(1, 0, 1, 1, AW'(m + 16), 1, m[0], m[1], 0); tick();
    end
    idle(1); tick(); tick();
    oe_n[1] = 1'b0; pipe[1] = 1'b0;

    phase = "R6 deselected port";
    drive(0, 0, 1, 1, 8, 0, 0, 0, pat(8, 9)); cs0_n[0] = 1'b1; tick();
    drive(0, 0, 1, 1, 9, 0, 0, 0, pat(9, 9)); cs1[0] = 1'b0; tick();
    drive(0, 0, 1, 1, 9, 1, 0, 0, 0); cs1[0] = 1'b0; tick();
    idle(0);
    drive(1, 0, 1, 1, 8, 1, 0, 0, 0); tick();
    drive(1, 1, 0, 1, 0, 1, 0, 0, 0); tick();
    idle(1); tick();

    phase = "R11 same-word write collision";
    drive(0, 0, 1, 1, 7, 0, 0, 1, pat(7, 2));
    drive(1, 0, 1, 1, 7, 0, 0, 0, pat(7, 3)); tick();
    drive(0, 0, 1, 1, 10, 0, 0, 0, pat(10, 2));
    drive(1, 0, 1, 1, 10, 0, 0, 0, pat(10, 3)); tick();
    drive(0, 0, 1, 1, 11, 0, 0, 0, pat(11, 2));
    drive(1, 0, 1, 1, 12, 0, 0, 0, pat(12, 3)); tick();
    idle(0);
    drive(1, 0, 1, 1, 7, 1, 0, 0, 0); tick();
    drive(1, 0, 1, 1, 10, 1, 0, 0, 0); tick();
    drive(1, 1, 0, 1, 0, 1, 0, 0, 0); tick();
    drive(1, 1, 0, 1, 0, 1, 0, 0, 0); tick();
    idle(1); tick();

    phase = "R12 read during other-port write";
    drive(0, 0, 1, 1, 13, 0, 0, 0, pat(13, 4));
    drive(1, 0, 1, 1, 13, 1, 0, 0, 0); tick();
    idle(0);
    drive(1, 0, 1, 1, 13, 1, 0, 0, 0); tick();
    idle(1); tick(); tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule